// File: doc/BRIEF.md
# Cell-Level Receive Master for a Single 8-bit PHY

This block is the receive half of the master side of an 8-bit cell-level ATM PHY link with one slave. It watches the slave's cell-available line. When the slave has a cell and the local cell buffer can take a whole cell, it drives an active-low read enable that requests one octet per cycle. The slave answers each enable it samples with one octet in the following cycle, so the block treats a sampled octet as valid only when its own enable was low one edge earlier.

The block hunts for start-of-cell and counts octets against a configured cell length. It hands every accepted octet to the buffer with a write strobe, and marks the first octet of each cell. It closes a cell with a commit pulse when the cell is good. It closes it with an abort pulse when the cell carried a parity error, or when start-of-cell came back before the cell was complete. Every abort comes with a one-cycle error pulse and a two-bit cause code.

The buffer side can pause the transfer at any time by raising a stall input. When the slave keeps cell-available high at a cell boundary, cells stream back to back with no gap. Otherwise the enable is released right after the last octet of the cell has been requested.

Top module: `utl1_rx_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `phy_enb_n` is 1 and `wr_en`, `wr_commit`, `wr_abort`, `err_pulse` and `err_stat` are all 0.
- R2: A new cell request starts only from a clock edge that samples `phy_clav`=1, `buf_room`=1 and `buf_stall`=0. `phy_enb_n` then goes low in the cycle after that edge. While `buf_room` is 0 and no cell is being requested, `phy_enb_n` stays 1.
- R3: Once a cell request has started, `phy_enb_n` is sampled low exactly `cell_len` times for that cell. At the edge that samples the last of them, the block either keeps `phy_enb_n` low for the next cell, if the R2 start condition holds there, or raises it. It therefore never requests octets the slave did not announce.
- R4: After any edge that samples `buf_stall`=1, `phy_enb_n` is 1. Requesting resumes when `buf_stall` returns to 0.
- R5: An octet on `phy_data`/`phy_soc`/`phy_par` is taken only at an edge whose previous edge sampled `phy_enb_n`=0. Its `wr_en` strobe is visible in the cycle after the edge that takes it, which is two cycles after the enable.
- R6: Valid octets that arrive while no cell is open and that have `phy_soc`=0 are dropped, with no strobe, pulse or error.
- R7: The octet that carries `phy_soc`=1 opens a cell and is written with `wr_sop`=1. The following octets are written with `wr_sop`=0 and `wr_data` equal to the sampled byte, in order.
- R8: With `par_chk_en`=1, an octet fails the parity check when the XOR of its 8 data bits and `phy_par` is 0, which is odd parity. A complete cell with at least one failing octet is closed by `wr_abort`, together with `err_pulse`=1 and `err_stat`=2'b01, in the same cycle as the strobe of its last octet.
- R9: A valid octet with `phy_soc`=1 that arrives while a cell is open with fewer than `cell_len` octets aborts that open cell. This produces `err_pulse`=1 with `err_stat[1]`=1 (length) and `err_stat[0]` set if a parity failure had been seen in the partial cell. It appears in the same cycle as the `wr_sop` strobe of the new cell.
- R10: A cell of exactly `cell_len` octets with no parity failure is closed by `wr_commit` in the same cycle as the strobe of its last octet. A cell is never both committed and aborted.
- R11: With `par_chk_en`=0, parity is ignored and a cell carrying wrong parity is committed.
- R12: `err_pulse` is high for one cycle for each errored cell, always together with `wr_abort`. `err_stat` is 0 whenever `err_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cell_len | input | 8 | Octets per cell (2 to 255), static during operation |
| par_chk_en | input | 1 | 1 enables the odd-parity check |
| phy_clav | input | 1 | Slave has a complete cell ready |
| phy_data | input | 8 | Octet driven by the slave |
| phy_soc | input | 1 | Slave marks the first octet of a cell |
| phy_par | input | 1 | Parity bit of `phy_data` |
| phy_enb_n | output | 1 | Active-low read enable to the slave |
| buf_room | input | 1 | Buffer can accept one full cell |
| buf_stall | input | 1 | Buffer asks to pause requests |
| wr_en | output | 1 | Octet write strobe |
| wr_data | output | 8 | Octet to write |
| wr_sop | output | 1 | Strobed octet is the first of a cell |
| wr_commit | output | 1 | Keep the open cell; it is complete and clean |
| wr_abort | output | 1 | Drop the open cell |
| err_pulse | output | 1 | One-cycle flag for a discarded cell |
| err_stat | output | 2 | Cause code: bit 0 parity, bit 1 length |

## Verification
If the enable counter drifts, `phy_enb_n` shows it within one cell. The enable run length at a boundary comes out different from `cell_len`, or the slave is asked for octets after its last announced one, which the slave model records as overrun. A wrong octet counter or wrong open-cell state shows at the next cell close: a commit lands on the wrong octet, a clean cell is aborted for length, or the committed bytes differ from what the slave sent. A wrong latency stage moves the first strobe away from two cycles after the first enable, and a stuck parity accumulator shows as a wrong cause code on the very next error pulse.

// File: rtl/utl1_rxm_pkg.sv
package utl1_rxm_pkg;

    // Discard cause code: bit 0 parity, bit 1 length
    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_PAR    = 2'b01,
        ERR_LEN    = 2'b10,
        ERR_LENPAR = 2'b11
    } err_code_e;

    // Helper to build a length-error code carrying the parity flag
    function automatic logic [1:0] len_code(input logic par_seen);
        return par_seen ? ERR_LENPAR : ERR_LEN;
    endfunction

endpackage

// File: rtl/utl1_rxm_par.sv
module utl1_rxm_par #(
    parameter int DW      = 8,
    parameter bit ODD_PAR = 1'b1
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          chk_en,
    output logic          bad
);
    logic ok;

    generate
        if (ODD_PAR) begin : g_odd
            assign ok = ^{data, par};
        end else begin : g_even
            assign ok = ~^{data, par};
        end
    endgenerate

    assign bad = chk_en & ~ok;
endmodule

// File: rtl/utl1_rxm_req.sv
module utl1_rxm_req #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cell_len,
    input  logic             clav,
    input  logic             room,
    input  logic             stall,
    output logic             enb_n
);
    typedef struct packed {
        logic             act;
        logic             enb_n;
        logic [LEN_W-1:0] iss;
    } req_t;

    localparam req_t REQ_RST = '{act: 1'b0, enb_n: 1'b1, iss: '0};

    req_t             s_d, s_q;
    logic             go;
    logic [LEN_W-1:0] iss_n;

    always_comb begin
        s_d   = s_q;
        go    = clav & room & ~stall;
        iss_n = s_q.iss + {{(LEN_W-1){1'b0}}, ~s_q.enb_n};
        if (!s_q.act) begin
            s_d.iss = '0;
            if (go) begin
                s_d.act   = 1'b1;
                s_d.enb_n = 1'b0;
            end else begin
                s_d.enb_n = 1'b1;
            end
        end else if (iss_n == cell_len) begin
            // last octet of the cell requested: continue or release
            s_d.iss = '0;
            if (go) begin
                s_d.enb_n = 1'b0;
            end else begin
                s_d.act   = 1'b0;
                s_d.enb_n = 1'b1;
            end
        end else begin
            s_d.iss   = iss_n;
            s_d.enb_n = stall;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= REQ_RST;
        else     s_q <= s_d;
    end

    assign enb_n = s_q.enb_n;
endmodule

// File: rtl/utl1_rxm_asm.sv
module utl1_rxm_asm
    import utl1_rxm_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cell_len,
    input  logic             enb_n,
    input  logic [DW-1:0]    data,
    input  logic             soc,
    input  logic             bad,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             wr_sop,
    output logic             wr_commit,
    output logic             wr_abort,
    output logic             err_pulse,
    output logic [1:0]       err_stat
);
    typedef struct packed {
        logic             pend;
        logic             in_cell;
        logic [LEN_W-1:0] cnt;
        logic             perr;
        logic             wr_en;
        logic [DW-1:0]    data;
        logic             sop;
        logic             commit;
        logic             abort;
        logic             err;
        logic [1:0]       stat;
    } asm_t;

    asm_t             s_d, s_q;
    logic [LEN_W-1:0] cnt_n;
    logic             perr_n;

    always_comb begin
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        s_d.sop    = 1'b0;
        s_d.commit = 1'b0;
        s_d.abort  = 1'b0;
        s_d.err    = 1'b0;
        s_d.stat   = ERR_NONE;
        // slave answers an enable one cycle later
        s_d.pend   = ~enb_n;
        cnt_n      = s_q.cnt + 1'b1;
        perr_n     = s_q.perr | bad;
        if (s_q.pend) begin
            if (soc) begin
                if (s_q.in_cell) begin
                    s_d.abort = 1'b1;
                    s_d.err   = 1'b1;
                    s_d.stat  = len_code(s_q.perr);
                end
                s_d.wr_en   = 1'b1;
                s_d.data    = data;
                s_d.sop     = 1'b1;
                s_d.in_cell = 1'b1;
                s_d.cnt     = {{(LEN_W-1){1'b0}}, 1'b1};
                s_d.perr    = bad;
            end else if (s_q.in_cell) begin
                s_d.wr_en = 1'b1;
                s_d.data  = data;
                if (cnt_n == cell_len) begin
                    s_d.in_cell = 1'b0;
                    s_d.cnt     = '0;
                    s_d.perr    = 1'b0;
                    if (perr_n) begin
                        s_d.abort = 1'b1;
                        s_d.err   = 1'b1;
                        s_d.stat  = ERR_PAR;
                    end else begin
                        s_d.commit = 1'b1;
                    end
                end else begin
                    s_d.cnt  = cnt_n;
                    s_d.perr = perr_n;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign wr_en     = s_q.wr_en;
    assign wr_data   = s_q.data;
    assign wr_sop    = s_q.sop;
    assign wr_commit = s_q.commit;
    assign wr_abort  = s_q.abort;
    assign err_pulse = s_q.err;
    assign err_stat  = s_q.stat;
endmodule

// File: rtl/utl1_rx_master.sv
module utl1_rx_master #(
    parameter int DW      = 8,
    parameter int LEN_W   = 8,
    parameter bit ODD_PAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cell_len,
    input  logic             par_chk_en,
    input  logic             phy_clav,
    input  logic [DW-1:0]    phy_data,
    input  logic             phy_soc,
    input  logic             phy_par,
    output logic             phy_enb_n,
    input  logic             buf_room,
    input  logic             buf_stall,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             wr_sop,
    output logic             wr_commit,
    output logic             wr_abort,
    output logic             err_pulse,
    output logic [1:0]       err_stat
);
    logic oct_bad;

    utl1_rxm_req #(.LEN_W(LEN_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .cell_len (cell_len),
        .clav     (phy_clav),
        .room     (buf_room),
        .stall    (buf_stall),
        .enb_n    (phy_enb_n)
    );

    utl1_rxm_par #(.DW(DW), .ODD_PAR(ODD_PAR)) u_par (
        .data   (phy_data),
        .par    (phy_par),
        .chk_en (par_chk_en),
        .bad    (oct_bad)
    );

    utl1_rxm_asm #(.DW(DW), .LEN_W(LEN_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .cell_len  (cell_len),
        .enb_n     (phy_enb_n),
        .data      (phy_data),
        .soc       (phy_soc),
        .bad       (oct_bad),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_sop    (wr_sop),
        .wr_commit (wr_commit),
        .wr_abort  (wr_abort),
        .err_pulse (err_pulse),
        .err_stat  (err_stat)
    );
endmodule

// File: rtl/utl1_rx_master_chk.sv
module utl1_rx_master_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [LEN_W-1:0] cell_len,
    input logic             phy_clav,
    input logic             phy_enb_n,
    input logic             buf_room,
    input logic             buf_stall,
    input logic             wr_en,
    input logic             wr_sop,
    input logic             wr_commit,
    input logic             wr_abort,
    input logic             err_pulse,
    input logic [1:0]       err_stat
);
    // independent count of sampled enables inside the current cell
    logic [LEN_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (!phy_enb_n) begin
            if (seen_q + 1'b1 == cell_len) seen_q <= '0;
            else                           seen_q <= seen_q + 1'b1;
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        (!phy_enb_n && seen_q == '0) |-> $past(phy_clav && buf_room && !buf_stall)); // R2
    AST_STALL_PAUSE: assert property (@(posedge clk) disable iff (rst)
        buf_stall |=> phy_enb_n); // R4
    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!phy_enb_n, 2)); // R5
    AST_LEN_ON_SOP: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_stat[1]) |-> (wr_en && wr_sop)); // R9
    AST_SINGLE_CLOSE: assert property (@(posedge clk) disable iff (rst)
        !(wr_commit && wr_abort)); // R10
    AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (wr_en && !wr_sop)); // R10
    AST_ERR_WITH_ABORT: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (wr_abort && err_stat != 2'b00)); // R12
    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> (err_stat == 2'b00)); // R12
endmodule

bind utl1_rx_master utl1_rx_master_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cell_len  (cell_len),
    .phy_clav  (phy_clav),
    .phy_enb_n (phy_enb_n),
    .buf_room  (buf_room),
    .buf_stall (buf_stall),
    .wr_en     (wr_en),
    .wr_sop    (wr_sop),
    .wr_commit (wr_commit),
    .wr_abort  (wr_abort),
    .err_pulse (err_pulse),
    .err_stat  (err_stat)
);

// File: tb/sim_utl1_rx_master.sv
module sim_utl1_rx_master;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit         is_err;
        logic [1:0] code;
        int         idx;
        string      tag;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cell_len = 8'd20;
    logic       par_chk_en = 1'b1;
    logic       phy_clav = 1'b0;
    logic [7:0] phy_data = '0;
    logic       phy_soc = 1'b0;
    logic       phy_par = 1'b0;
    logic       phy_enb_n;
    logic       buf_room = 1'b1;
    logic       buf_stall = 1'b0;
    logic       wr_en, wr_sop, wr_commit, wr_abort, err_pulse;
    logic [7:0] wr_data;
    logic [1:0] err_stat;

    utl1_rx_master u0 (
        .clk(clk), .rst(rst), .cell_len(cell_len), .par_chk_en(par_chk_en),
        .phy_clav(phy_clav), .phy_data(phy_data), .phy_soc(phy_soc), .phy_par(phy_par),
        .phy_enb_n(phy_enb_n), .buf_room(buf_room), .buf_stall(buf_stall),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_commit(wr_commit),
        .wr_abort(wr_abort), .err_pulse(err_pulse), .err_stat(err_stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // slave stream and expected events
    logic [7:0] st_d[$];
    bit         st_s[$];
    bit         st_p[$];
    ev_t        exp_q[$];
    logic [7:0] cur[$];
    int         pos = 0;
    int         overrun = 0;

    // flow controls applied at the next negedge
    bit rand_flow = 1'b0;
    bit room_v = 1'b1, stall_v = 1'b0, gate_v = 1'b1;
    bit prev_stall = 1'b0;
    bit en_now = 1'b0;

    // sampled outputs
    logic o_enb, o_wr, o_sop;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit good_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic push_oct(input logic [7:0] d, input bit s, input bit flip);
        st_d.push_back(d);
        st_s.push_back(s);
        st_p.push_back(good_par(d) ^ flip);
    endtask

    // returns 1 if any octet had parity flipped
    task automatic push_cell(input int n, input bit corrupt, output bit had_bad);
        int bi;
        bi = corrupt ? int'($urandom % n) : -1;
        had_bad = corrupt;
        for (int i = 0; i < n; i++) push_oct(8'($urandom), i == 0, i == bi);
    endtask

    task automatic add_full(input bit corrupt);
        ev_t e;
        bit  hb;
        e.idx = st_d.size();
        push_cell(int'(cell_len), corrupt, hb);
        e.is_err = hb && par_chk_en;
        e.code   = e.is_err ? 2'b01 : 2'b00;
        e.tag    = e.is_err ? "R8" : (hb ? "R11" : "R10");
        exp_q.push_back(e);
    endtask

    task automatic add_short_pair(input bit corrupt_a);
        ev_t e;
        bit  hb;
        int  s;
        s = 3 + int'($urandom % (int'(cell_len) - 6));
        e.idx = st_d.size();
        push_cell(s, corrupt_a, hb);
        e.is_err = 1'b1;
        e.code   = {1'b1, hb && par_chk_en};
        e.tag    = "R9";
        exp_q.push_back(e);
        e.idx = st_d.size();
        push_cell(int'(cell_len) - s, 1'b0, hb);
        e.code = 2'b10;
        exp_q.push_back(e);
        add_full(1'b0);
    endtask

    task automatic clear_stream();
        st_d.delete(); st_s.delete(); st_p.delete();
        exp_q.delete(); cur.delete();
        pos = 0; overrun = 0;
    endtask

    task automatic monitor();
        ev_t e;
        o_enb = phy_enb_n; o_wr = wr_en; o_sop = wr_sop;
        if (prev_stall) chk(phy_enb_n == 1'b1, "R4", "enable after stall", int'(phy_enb_n), 1);
        if (!err_pulse) chk(err_stat == 2'b00, "R12", "status without error", int'(err_stat), 0);
        if (wr_abort || err_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected discard code", int'(err_stat), 0);
            end else begin
                e = exp_q.pop_front();
                chk(e.is_err && wr_abort && err_pulse && err_stat == e.code, e.tag,
                    "discard code", int'({wr_abort, err_pulse, err_stat}), int'({e.is_err, e.is_err, e.code}));
            end
            cur.delete();
        end
        if (wr_en) begin
            if (wr_sop) cur.delete();
            cur.push_back(wr_data);
        end
        if (wr_commit) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected commit", 1, 0);
            end else begin
                bit ok;
                e = exp_q.pop_front();
                ok = !e.is_err && cur.size() == int'(cell_len);
                if (ok) for (int i = 0; i < cur.size(); i++) if (cur[i] !== st_d[e.idx + i]) ok = 1'b0;
                chk(ok, e.tag, "committed cell", cur.size(), int'(cell_len));
                if (cur.size() > 0 && cur.size() <= int'(cell_len))
                    chk(cur[0] === st_d[e.idx], "R7", "first octet", int'(cur[0]), int'(st_d[e.idx]));
            end
            cur.delete();
        end
    endtask

    task automatic step();
        int rem;
        @(negedge clk);
        monitor();
        en_now = !phy_enb_n;
        if (rand_flow) begin
            stall_v = ($urandom % 8) == 0;
            room_v  = ($urandom % 6) != 0;
            gate_v  = ($urandom % 5) != 0;
        end
        buf_stall  = stall_v;
        buf_room   = room_v;
        prev_stall = stall_v && !rst;
        rem = st_d.size() - pos - (en_now ? 1 : 0);
        phy_clav = (rem > 0) && gate_v;
        @(posedge clk);
        #1;
        if (en_now && !rst) begin
            if (pos < st_d.size()) begin
                phy_data = st_d[pos]; phy_soc = st_s[pos]; phy_par = st_p[pos];
                pos++;
            end else begin
                overrun++;
                phy_data = 8'($urandom); phy_soc = 1'b0; phy_par = 1'b0;
            end
        end else begin
            phy_data = 8'($urandom); phy_soc = 1'b0; phy_par = 1'($urandom);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) begin
            step();
            chk(o_enb == 1'b1 && o_wr == 1'b0 && !wr_commit && !wr_abort && !err_pulse && err_stat == 0,
                "R1", "reset outputs", int'({o_enb, o_wr}), 2);
        end
        rst = 1'b0;
        step();
        chk(o_enb == 1'b1 && o_wr == 1'b0, "R1", "first cycle after reset", int'({o_enb, o_wr}), 2);
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while (pos < st_d.size() && guard < 40000) begin step(); guard++; end
        rand_flow = 1'b0; stall_v = 1'b0; room_v = 1'b1; gate_v = 1'b1;
        repeat (12) step();
        chk(exp_q.size() == 0, req, "cells left unseen", exp_q.size(), 0);
        chk(overrun == 0, "R3", "octets requested beyond stream", overrun, 0);
    endtask

    initial begin
        int run;
        void'($urandom(32'h5eed_0042));

        // Phase 1: directed start gating and latency
        cell_len = 8'd20; par_chk_en = 1'b1;
        clear_stream();
        add_full(1'b0);
        room_v = 1'b0; gate_v = 1'b1; stall_v = 1'b0;
        do_reset();
        repeat (8) begin
            step();
            chk(o_enb == 1'b1, "R2", "enable while no room", int'(o_enb), 1);
        end
        room_v = 1'b1;
        step();
        step();
        chk(o_enb == 1'b0, "R2", "enable one cycle after room", int'(o_enb), 0);
        step();
        chk(o_wr == 1'b0, "R5", "no strobe one cycle after enable", int'(o_wr), 0);
        step();
        chk(o_wr == 1'b1 && o_sop == 1'b1, "R5", "first strobe two cycles after enable",
            int'({o_wr, o_sop}), 3);
        drain("R10");

        // Phase 2: hunt then random mix, parity on
        clear_stream();
        for (int i = 0; i < 20; i++) push_oct(8'($urandom), 1'b0, 1'b0);
        for (int k = 0; k < 40; k++) begin
            case ($urandom % 6)
                0, 1, 2: add_full(1'b0);
                3:       add_full(1'b1);
                4:       add_short_pair(1'b0);
                default: add_short_pair(1'b1);
            endcase
        end
        do_reset();
        rand_flow = 1'b1;
        drain("R6");

        // Phase 3: other length, parity check off
        cell_len = 8'd16; par_chk_en = 1'b0;
        clear_stream();
        for (int k = 0; k < 30; k++) begin
            case ($urandom % 4)
                0, 1:    add_full(1'b1);
                2:       add_full(1'b0);
                default: add_short_pair(1'b1);
            endcase
        end
        do_reset();
        rand_flow = 1'b1;
        drain("R11");

        // Phase 4: back-to-back cells, then release
        cell_len = 8'd20; par_chk_en = 1'b1;
        clear_stream();
        repeat (4) add_full(1'b0);
        do_reset();
        run = 0;
        for (int g = 0; g < 20 && o_enb == 1'b1; g++) step();
        while (o_enb == 1'b0 && run < 200) begin run++; step(); end
        chk(run == 4 * 20, "R3", "back-to-back enable run", run, 80);
        drain("R3");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule